// File: doc/BRIEF.md
# Radio Transceiver SPI Command Decoder

This block is the serial control port of a model low-power radio transceiver. A host drives an SPI mode 0 link (clock idle low, data sampled on the rising clock edge, changed on the falling edge). Each frame starts when chip select goes low, and the first byte of the frame is the opcode. The block decodes that opcode and then does one of these things: writes a configuration register, reads or writes the internal memory with an auto-incrementing address, loads bytes into the transmit FIFO, reads bytes out of the receive FIFO, or acts on a one-byte radio strobe. While the opcode is shifted in, a status byte is shifted out on MISO.

The SPI pins are sampled with the system clock through two-flop synchronisers. The serial clock must therefore be several times slower than the system clock. Behind the link sits a byte-addressed space with 12-bit addresses:

- Configuration registers occupy 0x000 to 0x03F.
- A 640-byte RAM is reached through two windows, 0x100 to 0x2FF and 0x380 to 0x3FF.
- The transmit FIFO is RAM 0x100 to 0x17F and the receive FIFO is RAM 0x180 to 0x1FF.
- The node's identity fields (network id at 0x3F2, short address at 0x3F4, 8-byte long address at 0x3EA) lie in the upper window.

Each recognised strobe is reported to the radio core as a one-cycle event that carries its code.

Top module: `radio_spi_cmd`

## Requirements
- R1: After reset, every register, RAM byte, FIFO pointer and status flag is zero, and MISO is driven low while chip select is high.
- R2: The byte shifted out during the opcode byte is the status byte. Its bits are: bit 7 = `xosc_ok`, bit 6 = `rssi_ok`, bit 3 = TX underflow, bit 1 = TX active, bit 0 = RX active, and bits 5, 4 and 2 = 0. It reflects the state left by all earlier frames.
- R3: Opcode 0b11aaaaaa writes the frame's second byte to register aaaaaa (address 0x000 to 0x03F). All further bytes of that frame are ignored.
- R4: Opcode 0x1h is a memory read. The second byte is the low 8 address bits and h gives the upper 4 bits. From the third byte on, MISO returns the byte at the address, and the address then advances by one (wrapping at 12 bits).
- R5: Opcode 0x2h is a memory write. The second byte is the low address, and every following byte is written at the address, which then advances by one.
- R6: Addresses 0x000 to 0x03F map to registers, 0x100 to 0x2FF map to RAM 0 to 511, and 0x380 to 0x3FF map to RAM 512 to 639. Any other address reads as 0x00 and ignores writes.
- R7: Opcode 0x3A appends every following byte to the TX FIFO at address 0x100 plus the TX count, and the count then advances. Once 128 bytes are held, further bytes are dropped.
- R8: Opcode 0x30 returns, from the second byte on, the bytes at 0x180 plus the RX read pointer. The pointer advances once per whole byte returned, wraps at 128 and persists across frames.
- R9: Strobe 0x42 sets RX active and clears TX active. Strobe 0x45 clears both. Strobe 0x00 only returns status. Each of 0x42, 0x44, 0x45, 0x47 and 0x48 raises `strobe_valid` for exactly one cycle, with its code on `strobe_code`.
- R10: Strobe 0x44 checks the TX FIFO against its first byte L (the frame length, which counts a 2-byte checksum not held in the FIFO). If the count is 0 or count+1 < L, it sets the underflow flag. Otherwise it sets TX active and clears RX active. Strobe 0x48 zeroes the TX count and clears the underflow flag. Strobe 0x47 zeroes the RX read pointer.
- R11: When chip select rises, any partly shifted byte is discarded with no effect, and the next frame starts again with an opcode.
- R12: Any other opcode returns status and has no effect: no strobe event, no change to state or memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, low when not selected |
| xosc_ok | input | 1 | Oscillator-stable flag from the radio core |
| rssi_ok | input | 1 | Signal-strength-valid flag from the radio core |
| strobe_valid | output | 1 | One-cycle pulse on each recognised strobe |
| strobe_code | output | 8 | Code of the strobe being reported |

## Verification
A wrong pointer or counter inside the block stays hidden until the host reads it. A TX count that is off shows up as a misplaced byte in a later memory read of the FIFO window, or as a wrong underflow verdict in the next frame's status byte. An RX pointer that is off shows up as the wrong byte on the very next receive-FIFO read, even one made several frames later. A wrong decode state shows up within the same frame, either as bytes written to the wrong address or as read data returned one byte early or late. The bench therefore reads back state through the normal opcodes immediately after every frame that could have changed it.

// File: rtl/radio_spi_pkg.sv
// Shared types and opcode values for the radio SPI command decoder.
// Assumes a 12-bit byte address space and 8-bit serial words.
package radio_spi_pkg;

    localparam int ADDR_W = 12;
    typedef logic [ADDR_W-1:0] maddr_t;

    // Decoder phase within one chip-select frame
    typedef enum logic [3:0] {
        PH_OPCODE,
        PH_REG_DATA,
        PH_RD_ADDR,
        PH_RD_DATA,
        PH_WR_ADDR,
        PH_WR_DATA,
        PH_TX_LOAD,
        PH_RX_READ,
        PH_DISCARD
    } phase_t;

    localparam logic [7:0] OP_NOP      = 8'h00;
    localparam logic [7:0] OP_RX_READ  = 8'h30;
    localparam logic [7:0] OP_TX_LOAD  = 8'h3A;
    localparam logic [7:0] OP_RX_ON    = 8'h42;
    localparam logic [7:0] OP_TX_CCA   = 8'h44;
    localparam logic [7:0] OP_RF_OFF   = 8'h45;
    localparam logic [7:0] OP_FLUSH_RX = 8'h47;
    localparam logic [7:0] OP_FLUSH_TX = 8'h48;

endpackage

// File: rtl/spi_link.sv
// Mode-0 SPI slave byte link, oversampled by the system clock.
// Assumes sclk runs well below clk/8 so that two-flop synchronisers plus
// edge detection settle between serial edges. Emits a one-cycle byte_done
// with the received byte; loads the status byte at frame start and the
// next transmit byte on the first falling edge after each byte.
module spi_link #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [WORD_W-1:0] status_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              miso,
    output logic              in_frame,
    output logic              byte_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BW = $clog2(WORD_W);

    logic [2:0]        sclk_sr;
    logic [2:0]        cs_sr;
    logic [1:0]        mosi_sr;
    logic [BW-1:0]     bit_cnt;
    logic [WORD_W-1:0] shift_in;
    logic [WORD_W-1:0] shift_out;
    logic              sclk_rise, sclk_fall, cs_act, cs_fell;

    // Synchronise the three SPI inputs into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
        end else begin
            sclk_sr <= {sclk_sr[1:0], sclk};
            cs_sr   <= {cs_sr[1:0], cs_n};
            mosi_sr <= {mosi_sr[0], mosi};
        end
    end

    assign sclk_rise = sclk_sr[1] & ~sclk_sr[2];
    assign sclk_fall = ~sclk_sr[1] & sclk_sr[2];
    assign cs_act    = ~cs_sr[1];
    assign cs_fell   = ~cs_sr[1] & cs_sr[2];
    assign in_frame  = cs_act;
    assign miso      = cs_act & shift_out[WORD_W-1];

    // Shift bits in on rising edges and out on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bit_cnt   <= '0;
            shift_in  <= '0;
            byte_done <= 1'b0;
            if (!rst_n) begin
                rx_word   <= '0;
                shift_out <= '0;
            end
        end else if (cs_fell) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            shift_out <= status_i;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                shift_in <= {shift_in[WORD_W-2:0], mosi_sr[1]};
                bit_cnt  <= bit_cnt + 1'b1;
                if (bit_cnt == BW'(WORD_W - 1)) begin
                    byte_done <= 1'b1;
                    rx_word   <= {shift_in[WORD_W-2:0], mosi_sr[1]};
                end
            end
            if (sclk_fall) begin
                if (bit_cnt == '0) shift_out <= tx_word_i;
                else               shift_out <= {shift_out[WORD_W-2:0], 1'b0};
            end
        end
    end

    assert_byte_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(cs_act));
    assert_deselect_drops_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_cnt == '0));

endmodule

// File: rtl/radio_store.sv
// Register file plus windowed RAM behind the decoder.
// One combinational read port and one write port on a 12-bit logical
// address. Unmapped addresses read zero and ignore writes.
module radio_store
    import radio_spi_pkg::*;
#(
    parameter int REG_COUNT = 64,
    parameter int RAM_BYTES = 640,
    parameter int LOW_BASE  = 'h100,
    parameter int LOW_SPAN  = 512,
    parameter int HIGH_BASE = 'h380
) (
    input  logic       clk,
    input  logic       rst_n,
    input  maddr_t     rd_addr,
    output logic [7:0] rd_data,
    input  logic       wr_en,
    input  maddr_t     wr_addr,
    input  logic [7:0] wr_data
);
    localparam int     RIW    = $clog2(RAM_BYTES);
    localparam int     GIW    = $clog2(REG_COUNT);
    localparam maddr_t REG_END = maddr_t'(REG_COUNT);
    localparam maddr_t LO_BEG  = maddr_t'(LOW_BASE);
    localparam maddr_t LO_END  = maddr_t'(LOW_BASE + LOW_SPAN);
    localparam maddr_t HI_BEG  = maddr_t'(HIGH_BASE);
    localparam maddr_t HI_END  = maddr_t'(HIGH_BASE + RAM_BYTES - LOW_SPAN);

    logic [7:0] regs [REG_COUNT];
    logic [7:0] ram  [RAM_BYTES];

    function automatic logic hits_reg(maddr_t a);
        return a < REG_END;
    endfunction

    function automatic logic hits_ram(maddr_t a);
        return (a >= LO_BEG && a < LO_END) || (a >= HI_BEG && a < HI_END);
    endfunction

    function automatic logic [RIW-1:0] ram_index(maddr_t a);
        if (a < LO_END) return RIW'(a - LO_BEG);
        return RIW'(a - HI_BEG + maddr_t'(LOW_SPAN));
    endfunction

    // Read mux over the two storage kinds
    always_comb begin
        if (hits_reg(rd_addr))      rd_data = regs[GIW'(rd_addr)];
        else if (hits_ram(rd_addr)) rd_data = ram[ram_index(rd_addr)];
        else                        rd_data = 8'h00;
    end

    // Write port with synchronous clear of all storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
            for (int i = 0; i < RAM_BYTES; i++) ram[i] <= '0;
        end else if (wr_en) begin
            if (hits_reg(wr_addr))      regs[GIW'(wr_addr)] <= wr_data;
            else if (hits_ram(wr_addr)) ram[ram_index(wr_addr)] <= wr_data;
        end
    end

endmodule

// File: rtl/cmd_engine.sv
// Opcode decoder and frame sequencer. Consumes one received byte per
// byte_done, drives the storage ports, keeps the FIFO pointers and the
// radio status flags, and prepares the next byte to be shifted out.
// Assumes byte_done pulses are separated by many clocks.
module cmd_engine
    import radio_spi_pkg::*;
#(
    parameter int     FIFO_BYTES = 128,
    parameter maddr_t TX_BASE    = 12'h100,
    parameter maddr_t RX_BASE    = 12'h180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_frame,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    input  logic       xosc_ok,
    input  logic       rssi_ok,
    output maddr_t     rd_addr,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output maddr_t     wr_addr,
    output logic [7:0] wr_data,
    output logic [7:0] status,
    output logic [7:0] tx_byte,
    output logic       strobe_valid,
    output logic [7:0] strobe_code
);
    localparam int PW = $clog2(FIFO_BYTES);

    phase_t        phase;
    maddr_t        addr;
    logic [PW:0]   tx_cnt;
    logic [PW-1:0] rx_ptr;
    logic [PW-1:0] rx_next;
    logic          underflow, tx_on, rx_on;
    logic          tx_room, flush_tx_now;

    assign status       = {xosc_ok, rssi_ok, 2'b00, underflow, 1'b0, tx_on, rx_on};
    assign rx_next      = rx_ptr + 1'b1;
    assign tx_room      = int'(tx_cnt) < FIFO_BYTES;
    assign flush_tx_now = byte_done && in_frame && phase == PH_OPCODE && rx_byte == OP_FLUSH_TX;

    // Read address for the byte that will be shifted out next
    always_comb begin
        case (phase)
            PH_OPCODE:  rd_addr = (rx_byte == OP_RX_READ) ? RX_BASE + maddr_t'(rx_ptr) : TX_BASE;
            PH_RD_ADDR: rd_addr = {addr[11:8], rx_byte};
            PH_RD_DATA: rd_addr = addr + 1'b1;
            PH_RX_READ: rd_addr = RX_BASE + maddr_t'(rx_next);
            default:    rd_addr = TX_BASE;
        endcase
    end

    // Storage write request for data-carrying phases
    always_comb begin
        wr_data = rx_byte;
        wr_addr = (phase == PH_TX_LOAD) ? TX_BASE + maddr_t'(tx_cnt[PW-1:0]) : addr;
        wr_en   = byte_done && in_frame &&
                  (phase == PH_REG_DATA || phase == PH_WR_DATA ||
                   (phase == PH_TX_LOAD && tx_room));
    end

    // Frame sequencing, pointers and radio flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_OPCODE;
            addr         <= '0;
            tx_cnt       <= '0;
            rx_ptr       <= '0;
            underflow    <= 1'b0;
            tx_on        <= 1'b0;
            rx_on        <= 1'b0;
            tx_byte      <= '0;
            strobe_valid <= 1'b0;
            strobe_code  <= '0;
        end else begin
            strobe_valid <= 1'b0;
            if (!in_frame) begin
                phase <= PH_OPCODE;
            end else if (byte_done) begin
                tx_byte <= status;
                case (phase)
                    PH_OPCODE: begin
                        phase <= PH_DISCARD;
                        if (rx_byte[7:6] == 2'b11) begin
                            addr  <= maddr_t'(rx_byte[5:0]);
                            phase <= PH_REG_DATA;
                        end else if (rx_byte[7:4] == 4'h1) begin
                            addr  <= {rx_byte[3:0], 8'h00};
                            phase <= PH_RD_ADDR;
                        end else if (rx_byte[7:4] == 4'h2) begin
                            addr  <= {rx_byte[3:0], 8'h00};
                            phase <= PH_WR_ADDR;
                        end else if (rx_byte == OP_TX_LOAD) begin
                            phase <= PH_TX_LOAD;
                        end else if (rx_byte == OP_RX_READ) begin
                            phase   <= PH_RX_READ;
                            tx_byte <= rd_data;
                        end else begin
                            case (rx_byte)
                                OP_RX_ON: begin
                                    rx_on <= 1'b1;
                                    tx_on <= 1'b0;
                                end
                                OP_TX_CCA: begin
                                    if (tx_cnt == '0 || int'(tx_cnt) + 1 < int'(rd_data))
                                        underflow <= 1'b1;
                                    else begin
                                        tx_on <= 1'b1;
                                        rx_on <= 1'b0;
                                    end
                                end
                                OP_RF_OFF: begin
                                    rx_on <= 1'b0;
                                    tx_on <= 1'b0;
                                end
                                OP_FLUSH_RX: rx_ptr <= '0;
                                OP_FLUSH_TX: begin
                                    tx_cnt    <= '0;
                                    underflow <= 1'b0;
                                end
                                default: ;
                            endcase
                            if (rx_byte == OP_RX_ON || rx_byte == OP_TX_CCA ||
                                rx_byte == OP_RF_OFF || rx_byte == OP_FLUSH_RX ||
                                rx_byte == OP_FLUSH_TX) begin
                                strobe_valid <= 1'b1;
                                strobe_code  <= rx_byte;
                            end
                        end
                    end
                    PH_REG_DATA: phase <= PH_DISCARD;
                    PH_RD_ADDR: begin
                        addr    <= {addr[11:8], rx_byte};
                        tx_byte <= rd_data;
                        phase   <= PH_RD_DATA;
                    end
                    PH_RD_DATA: begin
                        addr    <= addr + 1'b1;
                        tx_byte <= rd_data;
                    end
                    PH_WR_ADDR: begin
                        addr  <= {addr[11:8], rx_byte};
                        phase <= PH_WR_DATA;
                    end
                    PH_WR_DATA: addr <= addr + 1'b1;
                    PH_TX_LOAD: if (tx_room) tx_cnt <= tx_cnt + 1'b1;
                    PH_RX_READ: begin
                        rx_ptr  <= rx_next;
                        tx_byte <= rd_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_strobe_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_valid |=> !strobe_valid);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= FIFO_BYTES);
    assert_tx_count_only_flush_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_tx_now |=> tx_cnt >= $past(tx_cnt));
    assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush_tx_now) |=> underflow);

endmodule

// File: rtl/radio_spi_cmd.sv
// Top of the radio SPI command decoder: serial link, opcode engine and
// register/RAM storage. Assumes SPI pins may be asynchronous to clk.
module radio_spi_cmd
    import radio_spi_pkg::*;
#(
    parameter int REG_COUNT  = 64,
    parameter int RAM_BYTES  = 640,
    parameter int FIFO_BYTES = 128,
    parameter int LOW_SPAN   = 512,
    parameter int HIGH_BASE  = 'h380,
    parameter int TX_BASE    = 'h100,
    parameter int RX_BASE    = 'h180
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    input  logic       xosc_ok,
    input  logic       rssi_ok,
    output logic       strobe_valid,
    output logic [7:0] strobe_code
);
    logic       in_frame, byte_done, wr_en;
    logic [7:0] rx_byte, rd_data, wr_data, status, tx_byte;
    maddr_t     rd_addr, wr_addr;

    spi_link #(.WORD_W(8)) u_link (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .status_i(status), .tx_word_i(tx_byte), .miso(miso),
        .in_frame(in_frame), .byte_done(byte_done), .rx_word(rx_byte)
    );

    cmd_engine #(
        .FIFO_BYTES(FIFO_BYTES),
        .TX_BASE(maddr_t'(TX_BASE)),
        .RX_BASE(maddr_t'(RX_BASE))
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .byte_done(byte_done),
        .rx_byte(rx_byte), .xosc_ok(xosc_ok), .rssi_ok(rssi_ok),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .status(status), .tx_byte(tx_byte),
        .strobe_valid(strobe_valid), .strobe_code(strobe_code)
    );

    radio_store #(
        .REG_COUNT(REG_COUNT), .RAM_BYTES(RAM_BYTES), .LOW_BASE(TX_BASE),
        .LOW_SPAN(LOW_SPAN), .HIGH_BASE(HIGH_BASE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

endmodule

// File: tb/tb_radio_spi_cmd.sv
// Bench for radio_spi_cmd: behavioural model of memory, pointers and
// flags predicts every returned byte and strobe event; idle MISO and
// strobe events are watched on every clock.
module tb_radio_spi_cmd;
    localparam int HP = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic xosc_ok = 1'b0, rssi_ok = 1'b0;
    logic miso, strobe_valid;
    logic [7:0] strobe_code;

    radio_spi_cmd dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .xosc_ok(xosc_ok), .rssi_ok(rssi_ok),
        .strobe_valid(strobe_valid), .strobe_code(strobe_code)
    );

    int checks = 0, fails = 0, idle_bad = 0, idle_run = 0;
    bit done = 0;

    logic [7:0] mm [0:4095];
    int  m_txcnt = 0, m_rxptr = 0;
    bit  m_uf = 0, m_txon = 0, m_rxon = 0;
    logic [7:0] txq[$], gotq[$], expq[$], exp_strb[$], got_strb[$];
    bit cmpq[$];

    // Per-clock monitor: strobe events and idle MISO level
    always @(negedge clk) begin
        if (rst_n && strobe_valid) got_strb.push_back(strobe_code);
        if (cs_n) begin
            idle_run++;
            if (idle_run > 4 && miso !== 1'b0) idle_bad++;
        end else idle_run = 0;
    end

    function automatic bit mapped(int a);
        return (a < 64) || (a >= 256 && a < 768) || (a >= 896 && a < 1024);
    endfunction
    function automatic logic [7:0] m_rd(int a);
        return mapped(a) ? mm[a] : 8'h00;
    endfunction
    function automatic logic [7:0] m_stat();
        return {xosc_ok, rssi_ok, 2'b00, m_uf, 1'b0, m_txon, m_rxon};
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Model one frame: txq holds bytes, nfull of them complete
    task automatic model(int nfull);
        logic [7:0] op = txq[0];
        int a;
        expq.delete(); cmpq.delete();
        expq.push_back(m_stat()); cmpq.push_back(1);
        for (int i = 1; i < txq.size(); i++) begin expq.push_back(8'h00); cmpq.push_back(0); end
        if (nfull < 1) return;
        if (op[7:6] == 2'b11) begin
            if (nfull >= 2 && mapped(int'(op[5:0]))) mm[op[5:0]] = txq[1];
        end else if (op[7:4] == 4'h1) begin
            a = {op[3:0], txq[1]};
            for (int i = 2; i < nfull; i++) begin
                expq[i] = m_rd((a + i - 2) % 4096); cmpq[i] = 1;
            end
        end else if (op[7:4] == 4'h2) begin
            a = {op[3:0], txq[1]};
            for (int i = 2; i < nfull; i++)
                if (mapped((a + i - 2) % 4096)) mm[(a + i - 2) % 4096] = txq[i];
        end else if (op == 8'h3A) begin
            for (int i = 1; i < nfull; i++)
                if (m_txcnt < 128) begin mm[256 + m_txcnt] = txq[i]; m_txcnt++; end
        end else if (op == 8'h30) begin
            for (int i = 1; i < nfull; i++) begin
                expq[i] = mm[384 + ((m_rxptr + i - 1) % 128)]; cmpq[i] = 1;
            end
            m_rxptr = (m_rxptr + nfull - 1) % 128;
        end else begin
            case (op)
                8'h42: begin m_rxon = 1; m_txon = 0; end
                8'h44: if (m_txcnt == 0 || m_txcnt + 1 < int'(mm[256])) m_uf = 1;
                       else begin m_txon = 1; m_rxon = 0; end
                8'h45: begin m_rxon = 0; m_txon = 0; end
                8'h47: m_rxptr = 0;
                8'h48: begin m_txcnt = 0; m_uf = 0; end
                default: ;
            endcase
            if (op == 8'h42 || op == 8'h44 || op == 8'h45 || op == 8'h47 || op == 8'h48)
                exp_strb.push_back(op);
        end
    endtask

    // Drive one SPI frame; last byte may carry only last_bits bits
    task automatic frame(string req, int last_bits = 8);
        int nfull = (last_bits < 8) ? txq.size() - 1 : txq.size();
        logic [7:0] v;
        model(nfull);
        gotq.delete();
        @(negedge clk); cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int b = 0; b < txq.size(); b++) begin
            int nb = (b == txq.size() - 1) ? last_bits : 8;
            v = 8'h00;
            for (int k = 7; k >= 8 - nb; k--) begin
                mosi = txq[b][k];
                repeat (HP) @(negedge clk);
                v[k] = miso;
                sclk = 1'b1;
                repeat (HP) @(negedge clk);
                sclk = 1'b0;
            end
            gotq.push_back(v);
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1; mosi = 1'b0;
        repeat (HP + 4) @(negedge clk);
        for (int i = 0; i < nfull; i++)
            if (cmpq[i]) check(req, $sformatf("byte %0d op %02h", i, txq[0]), gotq[i], expq[i]);
        checks++;
        if (got_strb != exp_strb) begin
            fails++;
            $display("FAIL %s strobe events: actual %p expected %p", req, got_strb, exp_strb);
        end
        got_strb.delete(); exp_strb.delete();
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        checks++;
        if (idle_bad != 0) begin
            fails++;
            $display("FAIL R1 idle miso: actual %0d high samples expected 0", idle_bad);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4096; i++) mm[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R2: reset status, then live oscillator/RSSI bits
        txq = '{8'h00}; frame("R1");
        xosc_ok = 1'b1; rssi_ok = 1'b1;
        txq = '{8'h00}; frame("R2");
        txq = '{8'h10, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R1");

        // R3: register write, read back through memory read
        txq = '{8'hC5, 8'hA7, 8'h11}; frame("R3");
        txq = '{8'hFF, 8'h3C}; frame("R3");
        txq = '{8'h10, 8'h04, 8'h00, 8'h00, 8'h00}; frame("R3");
        txq = '{8'h10, 8'h3E, 8'h00, 8'h00, 8'h00}; frame("R3");

        // R4 R5 R6: burst writes across windows and holes
        txq = '{8'h23, 8'hEA, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                8'h9A, 8'hBC, 8'hDE, 8'hF0}; frame("R5");
        txq = '{8'h13, 8'hE9, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R4");
        txq = '{8'h22, 8'hFE, 8'h5A, 8'h6B, 8'h7C, 8'h8D}; frame("R6");
        txq = '{8'h12, 8'hFD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R6");
        txq = '{8'h20, 8'h3F, 8'h44, 8'h55}; frame("R6");
        txq = '{8'h10, 8'h3E, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R6");
        txq = '{8'h2F, 8'hFF, 8'h99}; frame("R6");
        txq = '{8'h1F, 8'hFF, 8'h00, 8'h00}; frame("R4");

        // R7 R10: TX load, good check, flush, short load, underflow
        txq = '{8'h48}; frame("R10");
        txq = '{8'h3A, 8'h05, 8'hA1, 8'hA2, 8'hA3}; frame("R7");
        txq = '{8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R7");
        txq = '{8'h44}; frame("R10");
        txq = '{8'h00}; frame("R10");
        txq = '{8'h48}; frame("R10");
        txq = '{8'h3A, 8'h09, 8'hB1, 8'hB2}; frame("R7");
        txq = '{8'h44}; frame("R10");
        txq = '{8'h00}; frame("R10");
        txq = '{8'h48}; frame("R10");
        txq = '{8'h44}; frame("R10");
        txq = '{8'h00}; frame("R10");
        txq = '{8'h48}; frame("R10");
        txq = '{8'h00}; frame("R10");

        // R9: radio on/off strobes
        txq = '{8'h42}; frame("R9");
        txq = '{8'h00}; frame("R9");
        txq = '{8'h45}; frame("R9");
        txq = '{8'h00}; frame("R9");

        // R8: RX FIFO reads continue across frames, flush rewinds
        txq = '{8'h21, 8'h80, 8'h0B, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6}; frame("R8");
        txq = '{8'h30, 8'h00, 8'h00, 8'h00}; frame("R8");
        txq = '{8'h30, 8'h00, 8'h00, 8'h00}; frame("R8");
        txq = '{8'h47}; frame("R10");
        txq = '{8'h30, 8'h00, 8'h00}; frame("R8");

        // R11: partial byte at deselect has no effect
        txq = '{8'h21, 8'h10, 8'hAA, 8'hFF}; frame("R11", 4);
        txq = '{8'h30, 8'hFF}; frame("R11", 3);
        txq = '{8'h11, 8'h10, 8'h00, 8'h00}; frame("R11");
        txq = '{8'h30, 8'h00}; frame("R11");

        // R12: unknown opcodes leave everything alone
        txq = '{8'h42}; frame("R9");
        txq = '{8'h7F, 8'h12, 8'h34}; frame("R12");
        txq = '{8'h3C, 8'h55}; frame("R12");
        txq = '{8'h00}; frame("R12");
        txq = '{8'h11, 8'h00, 8'h00}; frame("R12");

        // R7: fill beyond capacity, extra bytes dropped
        txq = '{8'h48}; frame("R7");
        txq.delete(); txq.push_back(8'h3A);
        for (int i = 0; i < 130; i++) txq.push_back(8'(i + 8'h20));
        frame("R7");
        txq = '{8'h11, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00}; frame("R7");
        txq = '{8'h11, 8'h00, 8'h00}; frame("R7");
        txq = '{8'h44}; frame("R10");
        txq = '{8'h00}; frame("R10");

        finish_run();
    end

endmodule